// File: doc/BRIEF.md
# Start-Gap Wear-Leveling Address Remapper

This block sits between a requester and a line-organised memory whose cells wear out with writes. It turns every logical line address into a physical line address. The memory holds `LINES` logical lines plus one spare physical line. At any moment one physical line is left empty, and that line is called the gap. Two registers set the mapping: a rotation offset and the position of the gap. The block keeps no table.

Each time `GAP_INTERVAL` demand writes have been accepted, the block moves the gap one line down. It sends the memory a line-move command that copies the neighbouring line into the gap slot. When the memory accepts the command, the block updates its two registers. When the gap passes below line 0, it wraps around to the top line and the rotation offset advances by one. Over time the hot logical lines drift across every physical line. Each move costs one extra line write for every `GAP_INTERVAL` demand writes.

Demand requests travel on a valid/ready stream, and the translated address comes out on a matching stream toward the memory. Back-pressure rules:
- Back-pressure from the memory side passes straight through to the requester.
- While a move is pending, the block deasserts `req_ready` and `mem_valid`.
- A request counts as accepted only in a cycle where `req_valid` and `req_ready` are both high.
- The line-move port is a valid/ready port of its own. Its command is held stable until the memory accepts it.

Top module: `sg_remapper`

## Requirements
- R1: After reset the rotation offset is 0 and the gap is at line `LINES`. This gives the identity mapping (physical = logical), with `busy` and `mv_valid` low.
- R2: The physical address is computed in two steps. First, raw = (logical + offset) mod `LINES`. Second, the physical address is raw + 1 when raw is greater than or equal to the gap, and raw otherwise. The result always lies in 0..`LINES`.
- R3: When not busy, `mem_valid` equals `req_valid`, `req_ready` equals `mem_ready`, and the write flag is forwarded unchanged.
- R4: Only accepted writes advance the write counter. Reads, and writes held off by `mem_ready` low, do not cause a move.
- R5: After the `GAP_INTERVAL`-th accepted write since the last move request, `busy` and `mv_valid` are high from the next cycle. They stay high until the move command is accepted.
- R6: When the gap is above 0, the move command copies line gap-1 (`mv_src`) into line gap (`mv_dst`). On acceptance the gap decreases by one.
- R7: When the gap is 0, the move command copies line `LINES` into line 0. On acceptance the gap returns to `LINES` and the offset advances by one, modulo `LINES`.
- R8: While `mv_valid` is high and `mv_ready` is low, `mv_valid`, `mv_src` and `mv_dst` hold their values.
- R9: While `busy` is high, no demand request is accepted (`req_ready` low) and none is presented to the memory (`mem_valid` low).
- R10: At all times the logical lines map one-to-one onto the physical lines, and no logical line maps onto the current gap line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Demand request valid |
| req_ready | output | 1 | Demand request accepted when high with valid |
| req_addr | input | LA_W | Logical line address, 0..LINES-1 |
| req_write | input | 1 | 1 = write, 0 = read |
| mem_valid | output | 1 | Translated request valid toward memory |
| mem_ready | input | 1 | Memory accepts translated request |
| mem_addr | output | PA_W | Physical line address, 0..LINES |
| mem_write | output | 1 | Forwarded write flag |
| busy | output | 1 | Gap move pending; demand traffic stalled |
| mv_valid | output | 1 | Line-move command valid |
| mv_ready | input | 1 | Memory has done the copy and accepts the command |
| mv_src | output | PA_W | Physical line to copy from |
| mv_dst | output | PA_W | Physical line to copy into (the gap) |

## Verification
The bench builds the block with `LINES` = 8 and `GAP_INTERVAL` = 4, so a move comes due after only four writes. Twenty moves are run, which walks the gap from the top line down through 0 twice. Both wrap-arounds of the offset are exercised, and the full mapping is compared against an independent model after every move. Stalled writes, read traffic and a move command held for several cycles are each exercised at these sizes.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic {
    MV_IDLE = 1'b0,
    MV_WAIT = 1'b1
  } mv_state_t;
endpackage

// File: rtl/sg_translate.sv
module sg_translate #(
  parameter int LINES = 16,
  parameter int LA_W  = 4,
  parameter int PA_W  = 5
) (
  input  logic [LA_W-1:0] la,
  input  logic [LA_W-1:0] start,
  input  logic [PA_W-1:0] gap,
  output logic [PA_W-1:0] pa
);
  localparam int EW = LA_W + 1;

  logic [EW-1:0] sum;
  logic [EW-1:0] raw;
  logic [EW-1:0] gap_e;

  always_comb begin
    sum   = {1'b0, la} + {1'b0, start};
    raw   = (sum >= EW'(LINES)) ? (sum - EW'(LINES)) : sum;
    gap_e = EW'(gap);
    if (raw >= gap_e) pa = PA_W'(raw + EW'(1));
    else              pa = PA_W'(raw);
  end
endmodule

// File: rtl/sg_wcount.sv
module sg_wcount #(
  parameter int GAP_INTERVAL = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_fire,
  output logic due
);
  localparam int CW = (GAP_INTERVAL > 1) ? $clog2(GAP_INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(GAP_INTERVAL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_fire) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + CW'(1);
    end
  end

  assign due = wr_fire && (cnt == LAST);
endmodule

// File: rtl/sg_gapctl.sv
module sg_gapctl
  import sg_pkg::*;
#(
  parameter int LINES = 16,
  parameter int LA_W  = 4,
  parameter int PA_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            due,
  input  logic            mv_ready,
  output logic            mv_valid,
  output logic [PA_W-1:0] mv_src,
  output logic [PA_W-1:0] mv_dst,
  output logic [LA_W-1:0] start,
  output logic [PA_W-1:0] gap
);
  localparam logic [PA_W-1:0] TOP   = PA_W'(LINES);
  localparam logic [LA_W-1:0] S_MAX = LA_W'(LINES - 1);

  mv_state_t state;
  logic      mv_fire;
  logic      gap_zero;

  assign mv_valid = (state == MV_WAIT);
  assign mv_fire  = mv_valid && mv_ready;
  assign gap_zero = (gap == '0);
  assign mv_src   = gap_zero ? TOP : (gap - PA_W'(1));
  assign mv_dst   = gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= MV_IDLE;
      start <= '0;
      gap   <= TOP;
    end else begin
      case (state)
        MV_IDLE: if (due) state <= MV_WAIT;
        MV_WAIT: if (mv_ready) state <= MV_IDLE;
        default: state <= MV_IDLE;
      endcase
      if (mv_fire) begin
        if (gap_zero) begin
          gap   <= TOP;
          start <= (start == S_MAX) ? '0 : (start + LA_W'(1));
        end else begin
          gap <= gap - PA_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sg_remapper.sv
module sg_remapper #(
  parameter int LINES        = 16,
  parameter int GAP_INTERVAL = 100,
  parameter int LA_W         = $clog2(LINES),
  parameter int PA_W         = $clog2(LINES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [LA_W-1:0] req_addr,
  input  logic            req_write,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [PA_W-1:0] mem_addr,
  output logic            mem_write,
  output logic            busy,
  output logic            mv_valid,
  input  logic            mv_ready,
  output logic [PA_W-1:0] mv_src,
  output logic [PA_W-1:0] mv_dst
);
  logic [LA_W-1:0] start;
  logic [PA_W-1:0] gap;
  logic            due;
  logic            wr_fire;

  assign busy      = mv_valid;
  assign mem_valid = req_valid && !busy;
  assign req_ready = mem_ready && !busy;
  assign mem_write = req_write;
  assign wr_fire   = req_valid && req_ready && req_write;

  sg_translate #(.LINES(LINES), .LA_W(LA_W), .PA_W(PA_W)) u_xlat (
    .la    (req_addr),
    .start (start),
    .gap   (gap),
    .pa    (mem_addr)
  );

  sg_wcount #(.GAP_INTERVAL(GAP_INTERVAL)) u_wcnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .due     (due)
  );

  sg_gapctl #(.LINES(LINES), .LA_W(LA_W), .PA_W(PA_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .due      (due),
    .mv_ready (mv_ready),
    .mv_valid (mv_valid),
    .mv_src   (mv_src),
    .mv_dst   (mv_dst),
    .start    (start),
    .gap      (gap)
  );
endmodule

// File: rtl/sg_remapper_chk.sv
module sg_remapper_chk #(
  parameter int LINES = 16,
  parameter int PA_W  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [PA_W-1:0] mem_addr,
  input logic            busy,
  input logic            mv_valid,
  input logic            mv_ready,
  input logic [PA_W-1:0] mv_src,
  input logic [PA_W-1:0] mv_dst
);
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr <= PA_W'(LINES)));  // R2
  AST_READY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ready);  // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mv_ready) |=> busy);  // R5
  AST_MOVE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_dst != '0) |-> (mv_src == mv_dst - PA_W'(1)));  // R6
  AST_MOVE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && mv_dst == '0) |-> (mv_src == PA_W'(LINES)));  // R7
  AST_MV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_src) && $stable(mv_dst)));  // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!req_ready && !mem_valid));  // R9
endmodule

bind sg_remapper sg_remapper_chk #(.LINES(LINES), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .busy      (busy),
  .mv_valid  (mv_valid),
  .mv_ready  (mv_ready),
  .mv_src    (mv_src),
  .mv_dst    (mv_dst)
);

// File: tb/sg_remapper_test.sv
module sg_remapper_test;
  localparam int PERIOD = 10;
  localparam int N      = 8;
  localparam int G      = 4;
  localparam int LA_W   = 3;
  localparam int PA_W   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [LA_W-1:0] req_addr = '0;
  logic            req_write = 1'b0;
  logic            mem_valid;
  logic            mem_ready = 1'b1;
  logic [PA_W-1:0] mem_addr;
  logic            mem_write;
  logic            busy;
  logic            mv_valid;
  logic            mv_ready = 1'b0;
  logic [PA_W-1:0] mv_src;
  logic [PA_W-1:0] mv_dst;

  int tests = 0;
  int fails = 0;
  int m_start = 0;
  int m_gap = N;

  always #(PERIOD/2) clk = ~clk;

  sg_remapper #(.LINES(N), .GAP_INTERVAL(G)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_write(mem_write),
    .busy(busy), .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_src(mv_src), .mv_dst(mv_dst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_pa(input int la);
    int raw = (la + m_start) % N;
    return (raw >= m_gap) ? raw + 1 : raw;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R2 / R10: full mapping against the model, one-to-one, gap never hit
  task automatic check_map(input string tag);
    bit [N:0] seen = '0;
    mem_ready = 1'b1;
    req_write = 1'b0;
    req_valid = 1'b1;
    for (int la = 0; la < N; la++) begin
      req_addr = LA_W'(la);
      #1;
      chk(int'(mem_addr) == model_pa(la), {tag, " R2 map"}, int'(mem_addr), model_pa(la));
      chk(!seen[mem_addr] && int'(mem_addr) != m_gap, {tag, " R10 bijection"}, int'(mem_addr), m_gap);
      seen[mem_addr] = 1'b1;
    end
    req_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk(!busy, "R1 busy", busy, 0);
    chk(!mv_valid, "R1 mv_valid", mv_valid, 0);
    for (int la = 0; la < N; la++) begin
      req_valid = 1'b1; req_addr = LA_W'(la); #1;
      chk(int'(mem_addr) == la, "R1 identity", int'(mem_addr), la);
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reads();
    for (int i = 0; i < 3 * G; i++) begin
      req_valid = 1'b1; req_write = 1'b0; req_addr = LA_W'(i % N); #1;
      chk(req_ready && mem_valid && !mem_write, "R3 read pass", int'(req_ready), 1);
      step();
    end
    req_valid = 1'b0; #1;
    chk(!busy, "R4 reads not counted", busy, 0);
  endtask

  task automatic t_backpressure();
    mem_ready = 1'b0;
    for (int i = 0; i < 2 * G; i++) begin
      req_valid = 1'b1; req_write = 1'b1; req_addr = LA_W'(i % N); #1;
      chk(!req_ready && mem_valid && mem_write, "R3 back-pressure", int'(req_ready), 0);
      step();
    end
    req_valid = 1'b0; mem_ready = 1'b1; #1;
    chk(!busy, "R4 stalled writes not counted", busy, 0);
  endtask

  task automatic t_move(input int hold);
    int exp_src;
    for (int i = 0; i < G; i++) begin
      #1;
      chk(!busy, "R5 not early", busy, 0);
      req_valid = 1'b1; req_write = 1'b1; req_addr = LA_W'(i % N);
      step();
    end
    req_valid = 1'b0; req_write = 1'b0; #1;
    exp_src = (m_gap == 0) ? N : m_gap - 1;
    chk(busy && mv_valid, "R5 move due", int'(mv_valid), 1);
    chk(int'(mv_dst) == m_gap, (m_gap == 0) ? "R7 dst" : "R6 dst", int'(mv_dst), m_gap);
    chk(int'(mv_src) == exp_src, (m_gap == 0) ? "R7 src" : "R6 src", int'(mv_src), exp_src);
    for (int h = 0; h < hold; h++) begin
      req_valid = 1'b1; req_write = 1'b1; #1;
      chk(!req_ready && !mem_valid, "R9 stall", int'(req_ready), 0);
      step();
      #1;
      chk(mv_valid && int'(mv_src) == exp_src && int'(mv_dst) == m_gap, "R8 hold", int'(mv_src), exp_src);
    end
    req_valid = 1'b0;
    mv_ready = 1'b1;
    step();
    mv_ready = 1'b0;
    if (m_gap == 0) begin
      m_gap = N;
      m_start = (m_start + 1) % N;
    end else begin
      m_gap = m_gap - 1;
    end
    #1;
    chk(!busy && !mv_valid, "R5 released", busy, 0);
    check_map("after move");
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    rst_n = 1'b1;
    t_reset();
    step();
    t_reads();
    t_backpressure();
    for (int m = 0; m < 20; m++) t_move(m % 3);
    chk(m_start == 2, "R7 offset wrapped twice", m_start, 2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule